// File: doc/BRIEF.md
# GPIB Service Request Responder

This block is the device-side service request function of an IEEE-488 bus interface. The host writes a serial poll status byte into a staging register; bit 6 of that byte (the request bit) asks for service. A second, auxiliary request flag can be set or cleared by the host on its own port. While either request is pending and no serial poll is under way, the block pulls the SRQ line. When the controller polls the device, the block supplies the status byte, which has bit 6 replaced by the request-status (RQS) indication. It then withdraws the request and pulses an interrupt once the byte has been handed over.

The talker, source handshake and controller functions live elsewhere. The block sees them only as two level inputs: `talker_spas` (talker in serial-poll-active state) and `sh_xfer` (source handshake in its transfer state). All inputs are sampled on the rising clock edge. The host ports are plain write strobes that take effect in the cycle they are sampled and never stall, so they have no back-pressure. The status byte is a level output, valid whenever `talker_spas` is high.

Top module: `gpib_srq_responder`

## Requirements
- R1: After `rst_n` is released, `srq` is 0, `poll_done` is 0, and `poll_byte` is 0x00.
- R2: From the idle state, if `talker_spas` is low and either staged bit 6 or the auxiliary flag is 1 at a clock edge, the block enters the requesting state and `srq` reads 1 after that edge.
- R3: In the requesting state, if `talker_spas` is low and both staged bit 6 and the auxiliary flag are 0 at a clock edge, the block returns to idle and `srq` drops.
- R4: In the requesting state, `talker_spas` high at a clock edge moves the block to the first poll-response state, and `srq` drops. `srq` is 1 in the requesting state and in no other state.
- R5: In the first poll-response state, both requests clear at an edge move the block to the second poll-response state. In the second poll-response state, `talker_spas` low at an edge returns the block to idle.
- R6: In either poll-response state, the auxiliary flag clears at any edge where `talker_spas` and `sh_xfer` are both high.
- R7: A host write sets the staging register at the edge. The staging register is copied into the output copy only at an edge where `talker_spas` is high and was low at the previous edge.
- R8: While `talker_spas` is high, `poll_byte` is the output copy with bit 6 replaced. Bit 6 reads 1 in either poll-response state and 0 in any other state. While `talker_spas` is low, `poll_byte` is 0x00.
- R9: `poll_done` is high for exactly one cycle, after an edge at which `sh_xfer` was sampled low having been high at the previous edge, while `talker_spas` is high and the block is in a poll-response state.
- R10: `sw_rst` high at an edge forces the idle state. It does not change the staging register, the output copy or the auxiliary flag.
- R11: A host write that leaves staged bit 6 at the same value does not change `srq`.
- R12: An auxiliary write at the same edge as a self-clear condition wins, so the flag takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_rst | input | 1 | Software reset of the request state |
| wr_stb | input | 1 | Write strobe for the staged status byte |
| wr_data | input | 8 | Status byte to stage, bit 6 = request |
| aux_wr | input | 1 | Write strobe for the auxiliary request flag |
| aux_val | input | 1 | Value written to the auxiliary flag |
| talker_spas | input | 1 | Talker is in serial-poll-active state |
| sh_xfer | input | 1 | Source handshake is in its transfer state |
| srq | output | 1 | Service request line (active high) |
| poll_byte | output | 8 | Status byte for the data lines during a poll |
| poll_done | output | 1 | One-cycle pulse when the poll byte has been transferred |

## Verification
The bench targets the double buffering, because a design that copied every write through would show a write made during a poll on the data lines at once. It checks that the request bit stays hidden when no request was granted. A design that only forced bit 6 high would leak the staged request bit onto the bus after a software reset taken in mid-poll. It also covers the self-clearing auxiliary flag. If that flag were not cleared during the transfer, `srq` would assert again as soon as the poll ended. Finally, it drives an auxiliary write at the same edge as a transfer, where a wrong priority would leave the flag in the wrong state.

// File: rtl/srq_pkg.sv
package srq_pkg;
  typedef enum logic [1:0] {
    SR_IDLE = 2'd0,
    SR_REQ  = 2'd1,
    SR_APR1 = 2'd2,
    SR_APR2 = 2'd3
  } sr_state_t;
endpackage

// File: rtl/srq_poll_regs.sv
module srq_poll_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic          aux_wr,
  input  logic          aux_val,
  input  logic          spas,
  input  logic          xfer,
  input  logic          in_apr,
  output logic [DW-1:0] stage_q,
  output logic [DW-1:0] out_q,
  output logic          rsv2_q,
  output logic          xfer_fall
);
  logic spas_d, xfer_d;
  logic spas_entry;

  assign spas_entry = spas & ~spas_d;
  assign xfer_fall  = xfer_d & ~xfer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      out_q   <= '0;
      rsv2_q  <= 1'b0;
      spas_d  <= 1'b0;
      xfer_d  <= 1'b0;
    end else begin
      spas_d <= spas;
      xfer_d <= xfer;
      if (wr_stb) stage_q <= wr_data;
      if (spas_entry) out_q <= stage_q;
      if (aux_wr) rsv2_q <= aux_val;
      else if (in_apr && spas && xfer) rsv2_q <= 1'b0;
    end
  end

  // R7: output copy frozen except on poll entry
  a_r7_copy_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !(spas && !spas_d) |=> $stable(out_q));
  // R6: self-clear of auxiliary request during transfer
  a_r6_rsv2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_apr && spas && xfer && !aux_wr) |=> !rsv2_q);
  // R12: host write wins
  a_r12_aux_wins: assert property (@(posedge clk) disable iff (!rst_n)
    aux_wr |=> (rsv2_q == $past(aux_val)));
endmodule

// File: rtl/srq_state_fsm.sv
module srq_state_fsm
  import srq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sw_rst,
  input  logic      spas,
  input  logic      req1,
  input  logic      req2,
  output sr_state_t st
);
  sr_state_t nxt;
  logic any_req;

  assign any_req = req1 | req2;

  always_comb begin
    nxt = st;
    unique case (st)
      SR_IDLE: if (!spas && any_req) nxt = SR_REQ;
      SR_REQ: begin
        if (spas) nxt = SR_APR1;
        else if (!any_req) nxt = SR_IDLE;
      end
      SR_APR1: if (!any_req) nxt = SR_APR2;
      SR_APR2: if (!spas) nxt = SR_IDLE;
      default: nxt = SR_IDLE;
    endcase
    if (sw_rst) nxt = SR_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= SR_IDLE;
    else        st <= nxt;
  end

  // R10: software reset forces idle
  a_r10_swrst: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> st == SR_IDLE);
  // R2: request entered only while no poll is active
  a_r2_req_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SR_IDLE && !sw_rst && !spas && any_req) |=> st == SR_REQ);
  // R5: second response state exits on poll end
  a_r5_apr2_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SR_APR2 && !spas) |=> st == SR_IDLE);
  // R4: poll entry from request
  a_r4_poll_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SR_REQ && spas && !sw_rst) |=> st == SR_APR1);
endmodule

// File: rtl/srq_poll_byte.sv
module srq_poll_byte #(
  parameter int DW     = 8,
  parameter int RQ_BIT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spas,
  input  logic          in_apr,
  input  logic          xfer_fall,
  input  logic [DW-1:0] out_q,
  output logic [DW-1:0] poll_byte,
  output logic          poll_done
);
  localparam logic [DW-1:0] RQ_MASK = DW'(1) << RQ_BIT;

  always_comb begin
    poll_byte = '0;
    if (spas) begin
      poll_byte = out_q & ~RQ_MASK;
      if (in_apr) poll_byte = poll_byte | RQ_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) poll_done <= 1'b0;
    else        poll_done <= xfer_fall & spas & in_apr;
  end

  // R9: interrupt is a single-cycle pulse
  a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    poll_done |=> !poll_done);
  // R8: idle bus carries no status
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !spas |-> poll_byte == '0);
endmodule

// File: rtl/gpib_srq_responder.sv
module gpib_srq_responder
  import srq_pkg::*;
#(
  parameter int DW     = 8,
  parameter int RQ_BIT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_rst,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic          aux_wr,
  input  logic          aux_val,
  input  logic          talker_spas,
  input  logic          sh_xfer,
  output logic          srq,
  output logic [DW-1:0] poll_byte,
  output logic          poll_done
);
  sr_state_t     st;
  logic [DW-1:0] stage_q, out_q;
  logic          rsv2_q, xfer_fall, in_apr;

  assign in_apr = (st == SR_APR1) || (st == SR_APR2);
  assign srq    = (st == SR_REQ);

  srq_poll_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .aux_wr(aux_wr), .aux_val(aux_val), .spas(talker_spas), .xfer(sh_xfer),
    .in_apr(in_apr), .stage_q(stage_q), .out_q(out_q), .rsv2_q(rsv2_q),
    .xfer_fall(xfer_fall)
  );

  srq_state_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .spas(talker_spas),
    .req1(stage_q[RQ_BIT]), .req2(rsv2_q), .st(st)
  );

  srq_poll_byte #(.DW(DW), .RQ_BIT(RQ_BIT)) u_byte (
    .clk(clk), .rst_n(rst_n), .spas(talker_spas), .in_apr(in_apr),
    .xfer_fall(xfer_fall), .out_q(out_q), .poll_byte(poll_byte),
    .poll_done(poll_done)
  );

  // R8: RQS bit shown during a granted poll
  a_r8_rqs: assert property (@(posedge clk) disable iff (!rst_n)
    (talker_spas && in_apr) |-> poll_byte[RQ_BIT]);
  // R4: request line never up while responding to a poll
  a_r4_srq_off: assert property (@(posedge clk) disable iff (!rst_n)
    in_apr |-> !srq);
endmodule

// File: tb/gpib_srq_responder_tb.sv
module gpib_srq_responder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_rst = 0, wr_stb = 0, aux_wr = 0, aux_val = 0, spas = 0, xfer = 0;
  logic [7:0] wr_data = '0;
  logic srq, poll_done;
  logic [7:0] poll_byte;

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model state: 0 idle, 1 req, 2 apr1, 3 apr2
  int m_st = 0;
  logic [7:0] m_stage = 0, m_out = 0;
  logic m_rsv2 = 0, m_spas_q = 0, m_xfer_q = 0, m_done = 0;

  always #2 clk = ~clk;

  gpib_srq_responder u_dut (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .wr_stb(wr_stb),
    .wr_data(wr_data), .aux_wr(aux_wr), .aux_val(aux_val),
    .talker_spas(spas), .sh_xfer(xfer), .srq(srq), .poll_byte(poll_byte),
    .poll_done(poll_done)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte();
    logic [7:0] b;
    if (!spas) return 8'h00;
    b = m_out & 8'hBF;
    if (m_st >= 2) b = b | 8'h40;
    return b;
  endfunction

  task automatic model_update();
    int nx;
    logic req, apr;
    req = m_stage[6] | m_rsv2;
    apr = (m_st >= 2);
    nx = m_st;
    case (m_st)
      0: if (!spas && req) nx = 1;
      1: if (spas) nx = 2; else if (!req) nx = 0;
      2: if (!req) nx = 3;
      default: if (!spas) nx = 0;
    endcase
    if (sw_rst) nx = 0;
    m_done = m_xfer_q && !xfer && spas && apr;
    if (aux_wr) m_rsv2 = aux_val;
    else if (apr && spas && xfer) m_rsv2 = 0;
    if (spas && !m_spas_q) m_out = m_stage;
    if (wr_stb) m_stage = wr_data;
    m_spas_q = spas;
    m_xfer_q = xfer;
    m_st = nx;
  endtask

  // one cycle: drive, compare, then advance model at the edge
  task automatic step(string tag, logic s, logic x, logic w = 0,
                      logic [7:0] d = 0, logic aw = 0, logic av = 0,
                      logic sr = 0);
    @(negedge clk);
    spas = s; xfer = x; wr_stb = w; wr_data = d;
    aux_wr = aw; aux_val = av; sw_rst = sr;
    #1;
    chk(tag, "srq", srq, (m_st == 1));
    chk(tag, "poll_byte", poll_byte, exp_byte());
    chk(tag, "poll_done", poll_done, m_done);
    @(posedge clk);
    model_update();
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state
    step("R1", 0, 0);
    step("R1", 0, 0);
    // R2: request bit staged
    step("R2", 0, 0, 1, 8'h45);
    step("R2", 0, 0);
    // R11: writes keeping bit 6 leave srq
    step("R11", 0, 0, 1, 8'h7F);
    step("R11", 0, 0, 1, 8'h41);
    step("R11", 0, 0);
    // R4: poll entry, R7 write during poll hidden
    step("R4", 1, 0);
    step("R7", 1, 0, 1, 8'h12);
    step("R7", 1, 1);
    // R9: transfer finished
    step("R9", 1, 0);
    step("R9", 1, 0);
    step("R9", 1, 0);
    // R5: stage cleared -> second response, then exit
    step("R5", 1, 0, 1, 8'h03);
    step("R5", 1, 0);
    step("R5", 0, 0);
    step("R5", 0, 0);
    // R3: aux request withdrawn before poll
    step("R3", 0, 0, 0, 0, 1, 1);
    step("R3", 0, 0);
    step("R3", 0, 0, 0, 0, 1, 0);
    step("R3", 0, 0);
    // R6: aux request self-clears in transfer
    step("R6", 0, 0, 0, 0, 1, 1);
    step("R6", 0, 0);
    step("R6", 1, 0);
    step("R6", 1, 1);
    step("R6", 1, 0);
    step("R6", 1, 0);
    step("R6", 0, 0);
    step("R6", 0, 0);
    step("R6", 0, 0);
    // R12: aux write beats self-clear
    step("R12", 0, 0, 0, 0, 1, 1);
    step("R12", 0, 0);
    step("R12", 1, 0);
    step("R12", 1, 1, 0, 0, 1, 1);
    step("R12", 1, 0);
    step("R12", 1, 0, 0, 0, 1, 0);
    step("R12", 1, 0);
    step("R12", 0, 0);
    step("R12", 0, 0);
    // R8/R10: request bit masked after sw reset in mid-poll
    step("R8", 0, 0, 1, 8'h7F);
    step("R8", 0, 0);
    step("R8", 1, 0);
    step("R10", 1, 0, 0, 0, 0, 0, 1);
    step("R10", 1, 0);
    step("R8", 1, 0, 1, 8'h00);
    step("R8", 0, 0);
    step("R10", 0, 0, 0, 0, 0, 0, 1);
    step("R10", 0, 0);
    // mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      step("R2", ($urandom % 4) != 0 ? spas : ~spas, 1'($urandom % 2),
           ($urandom % 6) == 0, d, ($urandom % 8) == 0, 1'($urandom % 2),
           ($urandom % 40) == 0);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule